// File: doc/BRIEF.md
# Load/Store-Multiple Micro-Op Sequencer

This block turns a single multi-register memory instruction into an ordered series of micro-ops. It emits one micro-op per cycle on a valid/ready output. A start strobe supplies the instruction:

- a 16-bit list of registers to transfer;
- a 4-bit base register index;
- a load or store selection;
- a writeback enable;
- an ascending or descending address direction;
- a user flag, which selects either user-bank access or the exception-return form.

Each emitted micro-op has these fields:

- an opcode;
- a destination and a source register field, where values 0 to 15 are architectural registers, 16 is scratch register 0 and 17 is scratch register 1;
- a 7-bit immediate;
- a direction bit;
- a user-bank tag;
- control, return and last flags.

The sequence always opens by copying the base into scratch register 0. One memory micro-op then follows per listed register, lowest index first, each addressed from scratch 0. When writeback is on, the base is adjusted once all memory micro-ops have been issued. For a load with writeback, the last listed register is first loaded into scratch register 1. A closing move places it in the last listed register only after the base update. A fault during the memory phase therefore never leaves the base modified.

Top module: `ldm_seq`

## Requirements
- R1: For a non-empty list of n registers, exactly n+1 micro-ops are emitted, plus 2 for a load with writeback or plus 1 for a store with writeback. An empty list yields exactly one micro-op.
- R2: The first micro-op has opcode add-immediate (0), destination 16 (scratch 0), source equal to the base register, immediate 0, and direction bit 0.
- R3: Memory micro-ops follow in ascending register order, one per set bit. Each has source 16, the data register in the destination field, and the direction bit equal to the ascending flag. Its opcode is load (2) or store (4). The i-th of n has immediate 4*i when ascending and 4*(n-1-i) when descending.
- R4: With writeback and a non-empty list, one micro-op follows the memory micro-ops. Its destination and source are the base, its immediate is 4*n and its direction bit equals the ascending flag. Its opcode is add-immediate (0) when ascending and subtract-immediate (1) when descending.
- R5: For a load with writeback, the last listed register is loaded into destination 17 with its user tag clear. A final move (opcode 5) then copies source 17 into that register.
- R6: When a load's list contains register 15 and the user flag is set, two micro-ops take the return form. The load of register 15 becomes load-return (3) when writeback is off. The final move becomes move-return (6), destination 15, when writeback is on.
- R7: When the user flag is set and list bit 15 is clear, the following micro-ops carry the user tag: every memory micro-op naming an architectural register, and the final move. No other micro-op carries it.
- R8: A plain final move to register 15 has the control flag set. It also has the return flag set when the base is 13. All other micro-ops have both flags clear.
- R9: Only the final micro-op of a sequence has the last flag set, and valid drops on the cycle after it is accepted.
- R10: After reset, valid and busy are low. The first micro-op is valid on the cycle after an accepted start. A start, and any change of the other inputs, while busy has no effect on the sequence.
- R11: While valid is high and ready is low, every output field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a new instruction when not busy |
| reg_list | input | 16 | Registers to transfer, one bit each |
| base_reg | input | 4 | Base register index |
| is_load | input | 1 | 1 = load, 0 = store |
| wback | input | 1 | Update the base after the transfer |
| ascend | input | 1 | 1 = ascending addresses |
| user_mode | input | 1 | User-bank / exception-return selector |
| busy | output | 1 | Sequence in progress, start ignored |
| uop_valid | output | 1 | Micro-op on the outputs is valid |
| uop_ready | input | 1 | Consumer accepts the micro-op |
| uop_op | output | 3 | Opcode |
| uop_dst | output | 5 | Destination / data register field |
| uop_src | output | 5 | Source / address base field |
| uop_imm | output | 7 | Immediate or byte offset |
| uop_up | output | 1 | Direction of the immediate |
| uop_usr | output | 1 | User-bank tag on the register field |
| uop_ctrl | output | 1 | Control-transfer flag |
| uop_ret | output | 1 | Return flag |
| uop_last | output | 1 | Final micro-op of the sequence |

## Verification
The checker watches several properties on every cycle:

- output fields hold while ready is low;
- the sequence continues or ends according to the last flag;
- the first micro-op after each accepted start is the base copy;
- memory micro-ops always address from scratch 0;
- only a plain move to register 15 is flagged as control;
- the accepted micro-op count agrees with the count captured at start.

Only the bench scenarios can show the detailed shape of each sequence. They cover the per-register offsets in both directions and the placement of the scratch-1 load and final move. They also cover the return-form substitutions, the user tagging, and the fact that inputs changed while busy are ignored. These are checked against a sequence computed from the rules above over a wide sweep of lists and all flag combinations.

// File: rtl/ldm_seq_pkg.sv
package ldm_seq_pkg;

    localparam int NREG    = 16;
    localparam int REGW    = $clog2(NREG);
    localparam int RIDW    = REGW + 1;
    localparam int CNTW    = $clog2(NREG + 1);
    localparam int IMMW    = $clog2(NREG * 4) + 1;
    localparam int PC_IDX  = NREG - 1;
    localparam int SP_IDX  = 13;

    localparam logic [RIDW-1:0] SCR0 = RIDW'(NREG);
    localparam logic [RIDW-1:0] SCR1 = RIDW'(NREG + 1);

    typedef enum logic [2:0] {
        OP_ADDI    = 3'd0,
        OP_SUBI    = 3'd1,
        OP_LOAD    = 3'd2,
        OP_LOADRET = 3'd3,
        OP_STORE   = 3'd4,
        OP_MOV     = 3'd5,
        OP_MOVRET  = 3'd6
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COPY,
        ST_MEM,
        ST_WB,
        ST_MOV
    } st_e;

    typedef struct packed {
        op_e             op;
        logic [RIDW-1:0] dst;
        logic [RIDW-1:0] src;
        logic [IMMW-1:0] imm;
        logic            up;
        logic            usr;
        logic            ctrl;
        logic            ret;
        logic            last;
    } uop_t;

    typedef struct packed {
        logic [REGW-1:0] base;
        logic            load;
        logic            wb;
        logic            asc;
        logic            exret;
        logic            fuser;
        logic [CNTW-1:0] total;
    } ctx_t;

    function automatic logic [IMMW-1:0] mem_offset(input logic asc,
                                                   input logic [CNTW-1:0] total,
                                                   input logic [CNTW-1:0] idx);
        logic [CNTW-1:0] slot;
        slot = asc ? idx : (total - idx - CNTW'(1));
        return IMMW'(slot) << 2;
    endfunction

    function automatic logic [IMMW-1:0] wb_amount(input logic [CNTW-1:0] total);
        return IMMW'(total) << 2;
    endfunction

endpackage

// File: rtl/ldm_lsb_pick.sv
module ldm_lsb_pick #(
    parameter int N = 16,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] pos,
    output logic         any,
    output logic [N-1:0] rest
);
    always_comb begin
        pos = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                pos = W'(i);
                any = 1'b1;
            end
        end
    end

    assign rest = vec & (vec - N'(1));
endmodule

// File: rtl/ldm_uop_form.sv
module ldm_uop_form
    import ldm_seq_pkg::*;
(
    input  st_e              st,
    input  ctx_t             ctx,
    input  logic [REGW-1:0]  cur_reg,
    input  logic [CNTW-1:0]  remain,
    input  logic [CNTW-1:0]  idx,
    input  logic [REGW-1:0]  last_reg,
    output uop_t             uop
);
    logic            last_mem;
    logic [RIDW-1:0] cur_id;
    logic [RIDW-1:0] base_id;
    logic [RIDW-1:0] last_id;

    assign last_mem = (remain == CNTW'(1));
    assign cur_id   = {1'b0, cur_reg};
    assign base_id  = {1'b0, ctx.base};
    assign last_id  = {1'b0, last_reg};

    always_comb begin
        uop = '0;
        uop.op = OP_ADDI;
        unique case (st)
            ST_COPY: begin                      // R2
                uop.op   = OP_ADDI;
                uop.dst  = SCR0;
                uop.src  = base_id;
                uop.imm  = '0;
                uop.last = (ctx.total == '0);
            end
            ST_MEM: begin                       // R3
                uop.src  = SCR0;
                uop.imm  = mem_offset(ctx.asc, ctx.total, idx);
                uop.up   = ctx.asc;
                uop.last = last_mem && !ctx.wb;
                if (ctx.load) begin
                    if (ctx.wb && last_mem) begin   // R5
                        uop.op  = OP_LOAD;
                        uop.dst = SCR1;
                    end else if (ctx.exret && cur_reg == REGW'(PC_IDX)) begin // R6
                        uop.op  = OP_LOADRET;
                        uop.dst = cur_id;
                        uop.usr = ctx.fuser;
                    end else begin
                        uop.op  = OP_LOAD;
                        uop.dst = cur_id;
                        uop.usr = ctx.fuser;    // R7
                    end
                end else begin
                    uop.op  = OP_STORE;
                    uop.dst = cur_id;
                    uop.usr = ctx.fuser;
                end
            end
            ST_WB: begin                        // R4
                uop.op   = ctx.asc ? OP_ADDI : OP_SUBI;
                uop.dst  = base_id;
                uop.src  = base_id;
                uop.imm  = wb_amount(ctx.total);
                uop.up   = ctx.asc;
                uop.last = !ctx.load;
            end
            ST_MOV: begin                       // R5
                uop.src  = SCR1;
                uop.last = 1'b1;
                if (ctx.exret) begin            // R6
                    uop.op  = OP_MOVRET;
                    uop.dst = RIDW'(PC_IDX);
                end else begin
                    uop.op   = OP_MOV;
                    uop.dst  = last_id;
                    uop.usr  = ctx.fuser;
                    uop.ctrl = (last_reg == REGW'(PC_IDX));        // R8
                    uop.ret  = (last_reg == REGW'(PC_IDX)) &&
                               (ctx.base == REGW'(SP_IDX));
                end
            end
            default: begin
                uop = '0;
                uop.op = OP_ADDI;
            end
        endcase
    end
endmodule

// File: rtl/ldm_seq.sv
module ldm_seq
    import ldm_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [15:0] reg_list,
    input  logic [3:0]  base_reg,
    input  logic        is_load,
    input  logic        wback,
    input  logic        ascend,
    input  logic        user_mode,
    output logic        busy,
    output logic        uop_valid,
    input  logic        uop_ready,
    output logic [2:0]  uop_op,
    output logic [4:0]  uop_dst,
    output logic [4:0]  uop_src,
    output logic [6:0]  uop_imm,
    output logic        uop_up,
    output logic        uop_usr,
    output logic        uop_ctrl,
    output logic        uop_ret,
    output logic        uop_last
);
    st_e             st_q;
    ctx_t            ctx_q;
    logic [NREG-1:0] list_q;
    logic [CNTW-1:0] remain_q;
    logic [CNTW-1:0] idx_q;
    logic [REGW-1:0] last_q;

    logic [REGW-1:0] cur_reg;
    logic            cur_any;
    logic [NREG-1:0] list_rest;
    logic [CNTW-1:0] in_count;
    logic            accept;
    logic            fire;
    uop_t            uop;

    ldm_lsb_pick #(.N(NREG), .W(REGW)) u_pick (
        .vec  (list_q),
        .pos  (cur_reg),
        .any  (cur_any),
        .rest (list_rest)
    );

    ldm_uop_form u_form (
        .st       (st_q),
        .ctx      (ctx_q),
        .cur_reg  (cur_reg),
        .remain   (remain_q),
        .idx      (idx_q),
        .last_reg (last_q),
        .uop      (uop)
    );

    assign in_count  = CNTW'($countones(reg_list));
    assign uop_valid = (st_q != ST_IDLE);
    assign busy      = uop_valid;
    assign accept    = start && !busy;          // R10
    assign fire      = uop_valid && uop_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= ST_IDLE;
            ctx_q    <= '0;
            list_q   <= '0;
            remain_q <= '0;
            idx_q    <= '0;
            last_q   <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (accept) begin
                        ctx_q.base  <= base_reg;
                        ctx_q.load  <= is_load;
                        ctx_q.wb    <= wback;
                        ctx_q.asc   <= ascend;
                        ctx_q.exret <= is_load && user_mode && reg_list[PC_IDX];
                        ctx_q.fuser <= user_mode && !reg_list[PC_IDX];
                        ctx_q.total <= in_count;
                        list_q      <= reg_list;
                        remain_q    <= in_count;
                        idx_q       <= '0;
                        st_q        <= ST_COPY;
                    end
                end
                ST_COPY: begin
                    if (fire) st_q <= (ctx_q.total == '0) ? ST_IDLE : ST_MEM;   // R1
                end
                ST_MEM: begin
                    if (fire && cur_any) begin
                        list_q   <= list_rest;
                        remain_q <= remain_q - CNTW'(1);
                        idx_q    <= idx_q + CNTW'(1);
                        last_q   <= cur_reg;
                        if (remain_q == CNTW'(1))
                            st_q <= ctx_q.wb ? ST_WB : ST_IDLE;
                    end
                end
                ST_WB: begin
                    if (fire) st_q <= ctx_q.load ? ST_MOV : ST_IDLE;
                end
                ST_MOV: begin
                    if (fire) st_q <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign uop_op   = uop.op;
    assign uop_dst  = uop.dst;
    assign uop_src  = uop.src;
    assign uop_imm  = uop.imm;
    assign uop_up   = uop.up;
    assign uop_usr  = uop.usr;
    assign uop_ctrl = uop.ctrl;
    assign uop_ret  = uop.ret;
    assign uop_last = uop.last;
endmodule

// File: rtl/ldm_seq_chk.sv
module ldm_seq_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic [15:0] reg_list,
    input logic [3:0]  base_reg,
    input logic        is_load,
    input logic        wback,
    input logic        busy,
    input logic        uop_valid,
    input logic        uop_ready,
    input logic [2:0]  uop_op,
    input logic [4:0]  uop_dst,
    input logic [4:0]  uop_src,
    input logic [6:0]  uop_imm,
    input logic        uop_up,
    input logic        uop_usr,
    input logic        uop_ctrl,
    input logic        uop_ret,
    input logic        uop_last
);
    logic [5:0] seen_q;
    logic [5:0] expect_q;
    logic [3:0] base_cap;
    logic [5:0] n_in;
    logic       acc;
    logic       fire;

    assign n_in = 6'($countones(reg_list));
    assign acc  = start && !busy;
    assign fire = uop_valid && uop_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q   <= '0;
            expect_q <= '0;
            base_cap <= '0;
        end else if (acc) begin
            seen_q   <= '0;
            base_cap <= base_reg;
            if (n_in == '0)
                expect_q <= 6'd1;
            else
                expect_q <= n_in + 6'd1 + (wback ? (is_load ? 6'd2 : 6'd1) : 6'd0);
        end else if (fire) begin
            seen_q <= seen_q + 6'd1;
        end
    end

    AST_UOP_COUNT: assert property (@(posedge clk) disable iff (rst)
        fire && uop_last |-> (seen_q + 6'd1 == expect_q));                // R1

    AST_FIRST_COPY: assert property (@(posedge clk) disable iff (rst)
        $rose(uop_valid) |-> (uop_op == 3'd0 && uop_dst == 5'd16 &&
                              uop_src == {1'b0, base_cap} && uop_imm == 7'd0)); // R2

    AST_MEM_FROM_SCR0: assert property (@(posedge clk) disable iff (rst)
        uop_valid && (uop_op == 3'd2 || uop_op == 3'd3 || uop_op == 3'd4)
        |-> uop_src == 5'd16);                                              // R3

    AST_CTRL_ONLY_MOV: assert property (@(posedge clk) disable iff (rst)
        uop_valid && (uop_ctrl || uop_ret) |-> (uop_op == 3'd5 && uop_dst == 5'd15)); // R8

    AST_LAST_ENDS: assert property (@(posedge clk) disable iff (rst)
        fire && uop_last |=> !uop_valid);                                   // R9

    AST_NOT_LAST_CONT: assert property (@(posedge clk) disable iff (rst)
        fire && !uop_last |=> uop_valid);                                   // R9

    AST_START_LATENCY: assert property (@(posedge clk) disable iff (rst)
        acc |=> uop_valid);                                                 // R10

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (rst)
        uop_valid && !uop_ready |=> uop_valid && $stable(uop_op) && $stable(uop_dst) &&
            $stable(uop_src) && $stable(uop_imm) && $stable(uop_up) && $stable(uop_usr) &&
            $stable(uop_ctrl) && $stable(uop_ret) && $stable(uop_last));    // R11
endmodule

bind ldm_seq ldm_seq_chk u_chk (.*);

// File: tb/ldm_seq_test.sv
`timescale 1ns/1ps
module ldm_seq_test;
    localparam logic [2:0] B_ADDI = 3'd0, B_SUBI = 3'd1, B_LOAD = 3'd2, B_LOADRET = 3'd3,
                           B_STORE = 3'd4, B_MOV = 3'd5, B_MOVRET = 3'd6;
    localparam int MAXU = 20;

    logic clk = 1'b0, rst = 1'b1, start = 1'b0;
    logic [15:0] reg_list = '0;
    logic [3:0]  base_reg = '0;
    logic is_load = 1'b0, wback = 1'b0, ascend = 1'b0, user_mode = 1'b0, uop_ready = 1'b0;
    logic busy, uop_valid, uop_up, uop_usr, uop_ctrl, uop_ret, uop_last;
    logic [2:0] uop_op;
    logic [4:0] uop_dst, uop_src;
    logic [6:0] uop_imm;

    ldm_seq uut (.*);

    always #4 clk = ~clk;

    int total = 0, bad = 0;
    logic [15:0] lf = 16'hACE1;

    logic [2:0] e_op  [MAXU];
    logic [4:0] e_dst [MAXU];
    logic [4:0] e_src [MAXU];
    logic [6:0] e_imm [MAXU];
    logic       e_up [MAXU], e_usr [MAXU], e_ctrl [MAXU], e_ret [MAXU], e_last [MAXU];
    string      e_tag [MAXU];
    int         e_n;

    function automatic logic [15:0] nxt(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic put(input logic [2:0] op, input logic [4:0] dst, input logic [4:0] src,
                       input logic [6:0] imm, input logic up, input logic usr,
                       input logic ctrl, input logic ret, input string tag);
        e_op[e_n] = op; e_dst[e_n] = dst; e_src[e_n] = src; e_imm[e_n] = imm;
        e_up[e_n] = up; e_usr[e_n] = usr; e_ctrl[e_n] = ctrl; e_ret[e_n] = ret;
        e_last[e_n] = 1'b0; e_tag[e_n] = tag;
        e_n++;
    endtask

    task automatic build(input logic [15:0] lst, input logic [3:0] b, input logic ld,
                         input logic wb, input logic up, input logic us);
        int n = 0, i = 0, lastr = 0;
        logic exr, fu;
        e_n = 0;
        for (int r = 0; r < 16; r++) if (lst[r]) n++;
        exr = ld && us && lst[15];
        fu  = us && !lst[15];
        put(B_ADDI, 5'd16, {1'b0, b}, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R2");
        for (int r = 0; r < 16; r++) begin
            if (lst[r]) begin
                logic [6:0] off;
                off = up ? 7'(4 * i) : 7'(4 * (n - 1 - i));
                if (ld && wb && i == n - 1)
                    put(B_LOAD, 5'd17, 5'd16, off, up, 1'b0, 1'b0, 1'b0, "R5");
                else if (exr && r == 15)
                    put(B_LOADRET, 5'd15, 5'd16, off, up, fu, 1'b0, 1'b0, "R6");
                else
                    put(ld ? B_LOAD : B_STORE, 5'(r), 5'd16, off, up, fu, 1'b0, 1'b0, "R3");
                i++;
                lastr = r;
            end
        end
        if (wb && n > 0) begin
            put(up ? B_ADDI : B_SUBI, {1'b0, b}, {1'b0, b}, 7'(4 * n), up, 1'b0, 1'b0, 1'b0, "R4");
            if (ld) begin
                if (exr)
                    put(B_MOVRET, 5'd15, 5'd17, 7'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
                else
                    put(B_MOV, 5'(lastr), 5'd17, 7'd0, 1'b0, fu, lastr == 15,
                        lastr == 15 && b == 4'd13, "R5");
            end
        end
        e_last[e_n - 1] = 1'b1;
    endtask

    function automatic logic [31:0] pack_now();
        return {7'd0, uop_op, uop_dst, uop_src, uop_imm, uop_up, uop_usr, uop_ctrl, uop_ret, uop_last};
    endfunction

    task automatic compare(input int k);
        chk({uop_op, uop_dst, uop_src, uop_imm, uop_up} == {e_op[k], e_dst[k], e_src[k], e_imm[k], e_up[k]},
            e_tag[k], $sformatf("uop %0d op/dst/src/imm/up", k),
            {11'd0, uop_op, uop_dst, uop_src, uop_imm, uop_up},
            {11'd0, e_op[k], e_dst[k], e_src[k], e_imm[k], e_up[k]});
        chk(uop_usr == e_usr[k], "R7", $sformatf("uop %0d user tag", k), 32'(uop_usr), 32'(e_usr[k]));
        chk({uop_ctrl, uop_ret} == {e_ctrl[k], e_ret[k]}, "R8", $sformatf("uop %0d ctrl/ret", k),
            32'({uop_ctrl, uop_ret}), 32'({e_ctrl[k], e_ret[k]}));
        chk(uop_last == e_last[k], "R9", $sformatf("uop %0d last", k), 32'(uop_last), 32'(e_last[k]));
    endtask

    task automatic run_one(input logic [15:0] lst, input logic [3:0] b, input logic ld,
                           input logic wb, input logic up, input logic us);
        int got = 0;
        bit done = 0, held = 0;
        logic [31:0] snap = '0;
        build(lst, b, ld, wb, up, us);
        reg_list = lst; base_reg = b; is_load = ld; wback = wb; ascend = up; user_mode = us;
        start = 1'b1; uop_ready = 1'b0;
        @(negedge clk);
        chk(uop_valid === 1'b1 && busy === 1'b1, "R10", "valid one cycle after start",
            32'({busy, uop_valid}), 32'h3);
        while (!done && got < 40) begin
            logic r;
            logic [31:0] now;
            lf  = nxt(lf);
            r   = lf[0] | lf[1];
            now = pack_now();
            if (held) chk(now == snap, "R11", "fields held while stalled", now, snap);
            held = 0;
            if (!uop_valid) begin
                chk(1'b0, "R9", "sequence ended early", 32'(got), 32'(e_n));
                done = 1;
            end else if (r) begin
                if (got < e_n) compare(got);
                else chk(1'b0, "R1", "extra micro-op", 32'(got + 1), 32'(e_n));
                got++;
                if (uop_last) done = 1;
            end else begin
                held = 1;
                snap = now;
            end
            start = lf[2]; reg_list = ~lst; base_reg = ~b;          // R10 ignored while busy
            is_load = ~ld; wback = ~wb; ascend = ~up; user_mode = ~us;
            uop_ready = r;
            @(negedge clk);
        end
        start = 1'b0; uop_ready = 1'b0;
        chk(!uop_valid && !busy, "R9", "idle after last", 32'({busy, uop_valid}), 32'h0);
        chk(got == e_n, "R1", "micro-op count", 32'(got), 32'(e_n));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] specials [6];
        specials[0] = 16'h0000; specials[1] = 16'h0001; specials[2] = 16'h8000;
        specials[3] = 16'hFFFF; specials[4] = 16'h8001; specials[5] = 16'hA010;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!uop_valid && !busy, "R10", "reset state", 32'({busy, uop_valid}), 32'h0);
        for (int li = 0; li < 196; li++) begin
            logic [15:0] lst;
            logic [3:0]  b;
            if (li < 6) lst = specials[li];
            else begin
                lf  = nxt(lf);
                lst = lf;
                if (li % 3 == 1) begin
                    lf  = nxt(lf);
                    lst = lst & lf;
                end
            end
            b = (li % 3 == 0) ? 4'd13 : 4'((li * 5) % 16);
            for (int f = 0; f < 16; f++)
                run_one(lst, b, f[0], f[1], f[2], f[3]);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule